// File: doc/BRIEF.md
# Programmable Interrupt Priority Controller

This controller sits between the interrupt sources of a processor subsystem and the core. Seven maskable sources compete for service: five on-chip peripherals (codec, host port, two serial ports, timer) and two active-low external pins. Software gives each of them a priority of 0, 1 or 2 in one read/write configuration register. The same register holds an enable bit and a trigger-mode bit for each external pin. Four non-maskable sources (reset, illegal instruction, stack error, software interrupt) always run at level 3.

Every cycle the block drops any maskable candidate whose level is below the core's two-bit mask. It then picks the highest remaining level and breaks ties with a fixed order. The winner's index, level and a valid flag are presented on registered outputs. When the core pulses acknowledge, the controller clears the stored edge event of the source it is showing at that moment.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the configuration register reads 0 and no request is valid. A write with reg_we_i is visible on reg_rdata_o one cycle later. Register layout: a 2-bit level field for each maskable source at bits [2k+1:2k], with k = 0 irqa, 1 irqb, 2 codec, 3 host, 4 serial 0, 5 serial 1, 6 timer. Bit 14 is the irqa enable, bit 15 the irqa trigger, bit 16 the irqb enable and bit 17 the irqb trigger.
- R2: Any asserted nmi_req_i bit wins over all maskable requests, whatever the mask. It is reported with level 3. Bit 0 is reset, bit 1 illegal instruction, bit 2 stack error and bit 3 software interrupt. The lowest set bit wins, and its bit number is the index.
- R3: A maskable request at level L can win only when L >= mask_i. With mask_i = 3 every maskable source is blocked.
- R4: Among the eligible maskable requests, the one with the highest level wins.
- R5: Ties within a level are broken in this order: irqa (index 4), irqb (5), codec (6), host (7), serial 0 (8), serial 1 (9), timer (10).
- R6: A level field value of 3 acts as level 2, both for arbitration and for the reported level.
- R7: A peripheral request on per_req_i (bit 0 codec, 1 host, 2 serial 0, 3 serial 1, 4 timer) takes part only while the matching per_en_i bit is 1.
- R8: When an external pin has its enable set and its trigger bit at 0 (low-level mode), it requests for as long as the pin is low. The request first shows on the outputs 3 cycles after the pin falls, and it is gone 3 cycles after the pin rises.
- R9: When an external pin has its enable set and its trigger bit at 1 (falling-edge mode), a synchronized falling edge is stored. The request shows 4 cycles after the fall and stays after the pin goes high again. It is cleared by ack_i while req_idx_o shows that pin's index, and the output drops the cycle after the acknowledge.
- R10: The outputs are registered and follow the inputs with one cycle of latency. An acknowledge does not affect a level-mode request, and a disabled pin never requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Configuration register write strobe |
| reg_wdata_i | input | 18 | Configuration register write data |
| reg_rdata_o | output | 18 | Configuration register read data |
| mask_i | input | 2 | Current processor priority mask |
| nmi_req_i | input | 4 | Non-maskable requests: reset, illegal, stack error, software |
| per_req_i | input | 5 | Peripheral requests: codec, host, serial 0, serial 1, timer |
| per_en_i | input | 5 | Peripheral enables, same bit order as per_req_i |
| irqa_ni | input | 1 | External interrupt pin A, active low, asynchronous |
| irqb_ni | input | 1 | External interrupt pin B, active low, asynchronous |
| ack_i | input | 1 | Core acknowledge pulse for the request being shown |
| req_valid_o | output | 1 | A request is presented |
| req_idx_o | output | 4 | Index of the winning source |
| req_lvl_o | output | 2 | Level of the winning source |

## Verification
Changes to a peripheral request, non-maskable request, mask, enable or acknowledge reach the outputs after one clock. A register write takes two clocks: one to store the value and one for the arbitration register. A pin in level mode takes three clocks, counting the two synchronizer flops. A pin in edge mode takes four, because the edge flop and the event latch add one more. The driver tags each expected result with the cycle it is due, taking the counter value at the falling edge where it applies the stimulus. The monitor compares each result at the falling edge of exactly that cycle. Some expectations are placed one cycle before a pin result is due and still expect the old output, so a design that is too fast is caught as well as one that is too slow.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned NMI_N  = 4;
  localparam int unsigned PER_N  = 5;
  localparam int unsigned EXT_N  = 2;
  localparam int unsigned MSK_N  = EXT_N + PER_N;
  localparam int unsigned NSRC   = NMI_N + MSK_N;
  localparam int unsigned IDX_W  = $clog2(NSRC);
  localparam int unsigned LVL_W  = 2;
  localparam int unsigned REG_W  = MSK_N * LVL_W + 2 * EXT_N;
  localparam int unsigned EN_BIT = MSK_N * LVL_W;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [IDX_W-1:0] idx_t;

  localparam lvl_t LVL_NMI = 2'd3;

  function automatic lvl_t clamp_lvl(input lvl_t f);
    return (f == 2'd3) ? 2'd2 : f;
  endfunction
endpackage

// File: rtl/irq_ext_pin.sv
module irq_ext_pin #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic en_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic req_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, latch_q, pin_low, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_ni};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pin_low = ~sync_q[SYNC_STAGES-1];
  assign fall    = prev_q & pin_low;

  // a new edge takes precedence over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   latch_q <= 1'b0;
    else if (!en_i || !edge_mode_i) latch_q <= 1'b0;
    else if (fall)                 latch_q <= 1'b1;
    else if (clr_i)                latch_q <= 1'b0;
  end

  // hide a latch being acknowledged so the next winner shows at once
  assign req_o = en_i & (edge_mode_i ? (latch_q & ~clr_i) : pin_low);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_prio_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic [N-1:0] req_i,
  input  lvl_t [N-1:0] lvl_i,
  input  lvl_t         mask_i,
  output logic         valid_o,
  output idx_t         idx_o,
  output lvl_t         lvl_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    // ascending scan with strict compare keeps the lower index on a tie
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (lvl_i[i] >= mask_i || lvl_i[i] == LVL_NMI)) begin
        if (!valid_o || lvl_i[i] > lvl_o) begin
          valid_o = 1'b1;
          idx_o   = idx_t'(i);
          lvl_o   = lvl_i[i];
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic [1:0]       mask_i,
  input  logic [NMI_N-1:0] nmi_req_i,
  input  logic [PER_N-1:0] per_req_i,
  input  logic [PER_N-1:0] per_en_i,
  input  logic             irqa_ni,
  input  logic             irqb_ni,
  input  logic             ack_i,
  output logic             req_valid_o,
  output logic [IDX_W-1:0] req_idx_o,
  output logic [1:0]       req_lvl_o
);
  logic [REG_W-1:0] cfg_q;
  logic [EXT_N-1:0] ext_pin_n, ext_req;
  logic [NSRC-1:0]  src_req;
  lvl_t [NSRC-1:0]  src_lvl;
  logic             arb_valid;
  idx_t             arb_idx;
  lvl_t             arb_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (reg_we_i) cfg_q <= reg_wdata_i;
  end
  assign reg_rdata_o = cfg_q;

  assign ext_pin_n = {irqb_ni, irqa_ni};

  for (genvar e = 0; e < EXT_N; e++) begin : g_ext
    logic clr;
    assign clr = ack_i & req_valid_o & (req_idx_o == idx_t'(NMI_N + e));
    irq_ext_pin #(.SYNC_STAGES(2)) i_pin (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_ni     (ext_pin_n[e]),
      .en_i       (cfg_q[EN_BIT + 2*e]),
      .edge_mode_i(cfg_q[EN_BIT + 2*e + 1]),
      .clr_i      (clr),
      .req_o      (ext_req[e])
    );
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    if (s < NMI_N) begin : g_nmi
      assign src_req[s] = nmi_req_i[s];
      assign src_lvl[s] = LVL_NMI;
    end else begin : g_msk
      localparam int unsigned K = s - NMI_N;
      assign src_lvl[s] = clamp_lvl(cfg_q[LVL_W*K +: LVL_W]);
      if (K < EXT_N) begin : g_x
        assign src_req[s] = ext_req[K];
      end else begin : g_p
        assign src_req[s] = per_req_i[K-EXT_N] & per_en_i[K-EXT_N];
      end
    end
  end

  irq_prio_arb #(.N(NSRC)) i_arb (
    .req_i  (src_req),
    .lvl_i  (src_lvl),
    .mask_i (mask_i),
    .valid_o(arb_valid),
    .idx_o  (arb_idx),
    .lvl_o  (arb_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_o <= 1'b0;
      req_idx_o   <= '0;
      req_lvl_o   <= '0;
    end else begin
      req_valid_o <= arb_valid;
      req_idx_o   <= arb_idx;
      req_lvl_o   <= arb_lvl;
    end
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mask_i,
  input logic [NMI_N-1:0] nmi_req_i,
  input logic [PER_N-1:0] per_en_i,
  input logic             req_valid_o,
  input logic [IDX_W-1:0] req_idx_o,
  input logic [1:0]       req_lvl_o
);
  logic             seen_q;
  logic [1:0]       mask_q;
  logic [NMI_N-1:0] nmi_q;
  logic [PER_N-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      mask_q <= '0;
      nmi_q  <= '0;
      en_q   <= '0;
    end else begin
      seen_q <= 1'b1;
      mask_q <= mask_i;
      nmi_q  <= nmi_req_i;
      en_q   <= per_en_i;
    end
  end

  a_r2_nmi_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && |nmi_q) |-> (req_valid_o && req_lvl_o == 2'd3));

  a_r2_lvl3_only_nmi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> ((req_lvl_o == 2'd3) == (req_idx_o < IDX_W'(NMI_N))));

  a_r3_mask_respected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && req_valid_o && req_lvl_o != 2'd3) |-> (req_lvl_o >= mask_q));

  a_r5_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_idx_o < IDX_W'(NSRC)));

  a_r7_enable_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && req_valid_o && req_idx_o >= IDX_W'(NMI_N + EXT_N) && req_idx_o < IDX_W'(NSRC))
      |-> en_q[req_idx_o - IDX_W'(NMI_N + EXT_N)]);
endmodule

bind irq_prio_ctrl irq_prio_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mask_i     (mask_i),
  .nmi_req_i  (nmi_req_i),
  .per_en_i   (per_en_i),
  .req_valid_o(req_valid_o),
  .req_idx_o  (req_idx_o),
  .req_lvl_o  (req_lvl_o)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [17:0] reg_wdata_i = '0;
  logic [17:0] reg_rdata_o;
  logic [1:0]  mask_i = '0;
  logic [3:0]  nmi_req_i = '0;
  logic [4:0]  per_req_i = '0;
  logic [4:0]  per_en_i = '0;
  logic        irqa_ni = 1'b1;
  logic        irqb_ni = 1'b1;
  logic        ack_i = 1'b0;
  logic        req_valid_o;
  logic [3:0]  req_idx_o;
  logic [1:0]  req_lvl_o;

  irq_prio_ctrl i_irq_prio_ctrl (.*);

  always #10 clk_i = ~clk_i;

  typedef struct {
    int    due;
    bit    v;
    int    idx;
    int    lvl;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor
  always @(negedge clk_i) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (e.due != cyc || req_valid_o !== e.v ||
          (e.v && (int'(req_idx_o) != e.idx || int'(req_lvl_o) != e.lvl))) begin
        n_err++;
        $display("FAIL %s cyc %0d: got v=%0b idx=%0d lvl=%0d, expected v=%0b idx=%0d lvl=%0d",
                 e.tag, cyc, req_valid_o, req_idx_o, req_lvl_o, e.v, e.idx, e.lvl);
      end
    end
  end

  task automatic expect_at(int d, bit v, int idx, int lvl, string tag);
    exp_t e;
    e.due = cyc + d; e.v = v; e.idx = idx; e.lvl = lvl; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk_i);
  endtask

  function automatic logic [17:0] cfg(input logic [1:0] la, lb, lc, lh, l0, l1, lt,
                                      input logic ea, ta, eb, tb);
    return {tb, eb, ta, ea, lt, l1, l0, lh, lc, lb, la};
  endfunction

  task automatic write_cfg(logic [17:0] v);
    reg_we_i = 1'b1; reg_wdata_i = v;
    tick(1);
    reg_we_i = 1'b0;
    n_chk++;
    if (reg_rdata_o !== v) begin
      n_err++;
      $display("FAIL R1 readback: got %h expected %h", reg_rdata_o, v);
    end
    tick(1);
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    n_chk++;
    if (reg_rdata_o !== 18'h0 || req_valid_o !== 1'b0) begin
      n_err++;
      $display("FAIL R1 reset: got rdata=%h v=%0b expected rdata=0 v=0", reg_rdata_o, req_valid_o);
    end

    // R7: disabled peripheral ignored, then enabled
    per_req_i = 5'b00001; per_en_i = 5'b00000;
    expect_at(1, 0, 0, 0, "R7 disabled codec"); drain();
    per_en_i = 5'b11111;
    expect_at(1, 1, 6, 0, "R10 codec lvl0 one cycle"); drain();

    // R3: mask 1 blocks level 0
    mask_i = 2'd1;
    expect_at(1, 0, 0, 0, "R3 mask blocks lvl0"); drain();
    mask_i = 2'd0;

    // R4: host lvl2 beats codec lvl1
    write_cfg(cfg(0, 0, 1, 2, 2, 2, 3, 0, 0, 0, 0));
    per_req_i = 5'b00011;
    expect_at(1, 1, 7, 2, "R4 host over codec"); drain();
    mask_i = 2'd2;
    per_req_i = 5'b00001;
    expect_at(1, 0, 0, 0, "R3 mask2 blocks codec lvl1"); drain();
    mask_i = 2'd0;

    // R5: tie order host before serial 0, then serial 0 alone
    per_req_i = 5'b00110;
    expect_at(1, 1, 7, 2, "R5 host before ser0"); drain();
    per_req_i = 5'b00100;
    expect_at(1, 1, 8, 2, "R5 ser0 alone"); drain();

    // R6: field 3 acts as 2
    per_req_i = 5'b10000;
    expect_at(1, 1, 10, 2, "R6 timer field3 reports lvl2"); drain();
    per_req_i = 5'b11000;
    expect_at(1, 1, 9, 2, "R6 ser1 ties timer, wins by order"); drain();

    // R2: non-maskable wins despite mask 3
    mask_i = 2'd3;
    nmi_req_i = 4'b1100;
    expect_at(1, 1, 2, 3, "R2 stack over swi"); drain();
    nmi_req_i = 4'b1101;
    expect_at(1, 1, 0, 3, "R2 reset first"); drain();
    nmi_req_i = 4'b0000;
    expect_at(1, 0, 0, 0, "R3 mask3 blocks all maskable"); drain();
    mask_i = 2'd0;
    per_req_i = 5'b00000;

    // R8: irqa low-level mode, level 1
    write_cfg(cfg(1, 2, 0, 0, 0, 0, 0, 1, 0, 0, 0));
    irqa_ni = 1'b0;
    expect_at(2, 0, 0, 0, "R8 not yet after 2");
    expect_at(3, 1, 4, 1, "R8 irqa level after 3"); drain();
    irqa_ni = 1'b1;
    expect_at(2, 1, 4, 1, "R8 still after 2");
    expect_at(3, 0, 0, 0, "R8 gone after 3"); drain();

    // R9: irqb falling edge, latched, level 2
    write_cfg(cfg(1, 2, 0, 0, 0, 0, 0, 0, 0, 1, 1));
    irqb_ni = 1'b0;
    expect_at(3, 0, 0, 0, "R9 not yet after 3");
    expect_at(4, 1, 5, 2, "R9 edge after 4");
    expect_at(7, 1, 5, 2, "R9 held after pin high");
    tick(1);
    irqb_ni = 1'b1;
    drain();
    ack_i = 1'b1;
    expect_at(1, 0, 0, 0, "R9 cleared by ack");
    tick(1);
    ack_i = 1'b0;
    expect_at(2, 0, 0, 0, "R9 stays cleared"); drain();

    // R10: ack leaves level request, disabled pin ignored
    write_cfg(cfg(1, 2, 0, 0, 0, 0, 0, 1, 0, 0, 1));
    irqa_ni = 1'b0;
    expect_at(3, 1, 4, 1, "R10 irqa level up"); drain();
    ack_i = 1'b1;
    expect_at(1, 1, 4, 1, "R10 ack no effect on level mode");
    tick(1);
    ack_i = 1'b0;
    drain();
    irqb_ni = 1'b0;
    expect_at(5, 1, 4, 1, "R10 disabled irqb ignored");
    tick(1);
    irqb_ni = 1'b1;
    drain();
    irqa_ni = 1'b1;
    expect_at(3, 0, 0, 0, "R8 irqa released"); drain();

    tick(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule